// File: doc/BRIEF.md
# Power-Up Strap Latch and Output Gating

This block sits between a clock synthesizer's frequency sources and its output pads. Several pads have two roles. They are configuration straps while the chip powers up, and clock outputs afterwards. A single strobe input has two roles as well. Its first high level means "supply good, straps valid". From then on it acts as an active-low power-down request.

While the block waits for that strobe, it keeps the shared pads in input mode. When the synchronized strobe is seen high, it captures the strap levels and the spread strap into the frequency configuration register, and it turns the shared pads into outputs. From then on it gates every output class with its own enable and applies that class's own disabled state. Each output is either driven low, tri-stated, or, for differential pairs, held low on both legs. An enable change takes effect only while the affected source waveform is low, so a gated output never shows a shortened pulse. A configuration code of all zeros tri-states the processor, serial-link and bus outputs. The code one feeds those outputs from the reference input divided down, as a bypass test mode.

All source waveforms are sampled in the `clk` domain. The analog oscillator, the PLLs and the pad drivers are outside this block.

Top module: `clk_strap_gate`

## Requirements
- R1: After reset and until the strobe has been accepted, `pin_out_mode` is 0, the shared pads are inputs (`ref12_oe` = 2'b00 and `c25_oe[0]` = 0), and every differential leg is 0.
- R2: `pgood_pd_n` passes through a two-stage synchronizer. Output mode starts on the third rising `clk` edge after the pin rises, and it lasts until reset.
- R3: On entry to output mode, `freq_cfg` becomes {3'b000, strap_ss, 1'b0, strap_fs[2:0]}. Bits [2:0] are the select code, bit 3 is the extra select bit, and bit 4 is spread. Later strap changes have no effect.
- R4: A write (`cfg_we`) stores `cfg_wdata[4:0]` only in output mode. Bits [7:5] always read 0. Writes before output mode are ignored, including a write held through the cycle in which the straps load.
- R5: In output mode, `cpu_oe`, `pcie_oe` and `pci_oe` are 0 when `freq_cfg[3:0]` = 4'b0000 and 1 for any other code.
- R6: With `freq_cfg[3:0]` = 4'b0001, the processor, serial-link and bus outputs run at the reference divided by 4, 8 and 24. Dividers count reference rising edges, start low, and toggle every half ratio.
- R7: For other codes, each enabled output follows its source input (`cpu_raw`, `src_raw`, `pci_raw`, `c48_raw`, `c25_raw`, `ref_raw`).
- R8: A change to an output's enable is taken only on a `clk` edge at which that output's source is low. While the source stays high, the old enable holds.
- R9: An enabled pair drives true = source and complement = inverted source. A disabled pair drives both legs 0.
- R10: Disabled states: ref1/ref2 (`ref12_oe` bit) and `c25[0]` (`c25_oe[0]`) are tri-stated. `ref0`, `pci_clk`, `c48` and `c25[1]` are driven 0, and `c25_oe[1]` stays 1.
- R11: In output mode, `pgood_pd_n` low forces every differential leg to 0 at once, with no clock edge needed. After the pin returns high, pairs resume only after the synchronizer and the next low-phase enable update.
- R12: `ref0` follows `ref_raw` and `en_ref[0]` alone, in every mode and during power-down. Its enable resets to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low standby reset |
| pgood_pd_n | input | 1 | Power-good strobe, then active-low power-down |
| strap_fs | input | 3 | Select strap levels on shared pads |
| strap_ss | input | 1 | Spread strap level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| ref_raw | input | 1 | Reference waveform |
| cpu_raw | input | 1 | Processor source waveform |
| src_raw | input | 1 | Serial-link source waveform |
| pci_raw | input | 1 | Bus clock source waveform |
| c48_raw | input | 1 | 48 MHz source waveform |
| c25_raw | input | 1 | 25 MHz source waveform |
| en_ref | input | 3 | Enables: bit0 ref0, bit1 ref1, bit2 ref2 |
| en_pci | input | N_PCI | Bus clock enables |
| en_48 | input | 2 | 48 MHz enables |
| en_25 | input | 2 | 25 MHz enables (bit0 tri-state type, bit1 low type) |
| en_cpu | input | N_CPU | Processor pair enables |
| en_pcie | input | N_PCIE | Serial-link pair enables |
| pin_out_mode | output | 1 | Shared pads are in output mode |
| freq_cfg | output | 8 | Frequency configuration register |
| ref0 | output | 1 | Free-running reference output |
| ref12 | output | 2 | ref1/ref2 data |
| ref12_oe | output | 2 | ref1/ref2 output enables |
| pci_clk | output | N_PCI | Bus clocks |
| pci_oe | output | 1 | Bus clock output enable |
| c48 | output | 2 | 48 MHz outputs |
| c25 | output | 2 | 25 MHz outputs |
| c25_oe | output | 2 | 25 MHz output enables |
| cpu_t | output | N_CPU | Processor pair true legs |
| cpu_c | output | N_CPU | Processor pair complement legs |
| cpu_oe | output | 1 | Processor pair output enable |
| pcie_t | output | N_PCIE | Serial-link pair true legs |
| pcie_c | output | N_PCIE | Serial-link pair complement legs |
| pcie_oe | output | 1 | Serial-link pair output enable |

## Verification
The strap load and a register write can land on the same clock edge. The bench holds `cfg_we` high with data 8'h1F from before the strobe rises until after output mode begins. It then expects the strap image 8'h15 on the edge of entry and no write in the cycles before. A second collision is between a power-down assertion and a pending low-phase enable update. Pulling the strobe low while the sources are low must clear the complement legs within the same time step. The bench then counts exactly three edges before the legs return.

// File: rtl/clk_strap_gate_pkg.sv
package clk_strap_gate_pkg;

    typedef enum logic [1:0] {
        GATE_LOW  = 2'd0,
        GATE_HIZ  = 2'd1,
        GATE_PAIR = 2'd2
    } gate_mode_e;

    localparam int CFG_W    = 5;
    localparam int CFG_BYTE = 8;
    localparam int FS_W     = 4;

    localparam logic [FS_W-1:0] FS_HIZ    = 4'b0000;
    localparam logic [FS_W-1:0] FS_BYPASS = 4'b0001;

    typedef struct packed {
        logic             run;
        logic [CFG_W-1:0] cfg;
    } strap_state_t;

    typedef struct packed {
        logic [1:0] sync;
    } sync_state_t;

endpackage

// File: rtl/strap_ctl.sv
module strap_ctl
    import clk_strap_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pgood_pd_n,
    input  logic [2:0]          strap_fs,
    input  logic                strap_ss,
    input  logic                cfg_we,
    input  logic [CFG_BYTE-1:0] cfg_wdata,
    output logic                run,
    output logic                pd_ok,
    output logic [CFG_W-1:0]    cfg
);

    logic         sync_clr_n;
    sync_state_t  sy_d, sy_q;
    strap_state_t st_d, st_q;
    logic [CFG_BYTE-CFG_W-1:0] unused_wdata_hi;

    assign sync_clr_n      = rst_n & pgood_pd_n;
    assign unused_wdata_hi = cfg_wdata[CFG_BYTE-1:CFG_W];

    // Synchronizer: cleared at once when the pin drops, set only after two edges.
    always_comb begin
        sy_d      = sy_q;
        sy_d.sync = {sy_q.sync[0], 1'b1};
    end

    always_ff @(posedge clk or negedge sync_clr_n) begin
        if (!sync_clr_n) sy_q <= '0;
        else             sy_q <= sy_d;
    end

    assign pd_ok = sy_q.sync[1];

    // Strap capture and configuration register.
    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (pd_ok) begin
                st_d.run = 1'b1;
                st_d.cfg = {strap_ss, 1'b0, strap_fs};
            end
        end else if (cfg_we) begin
            st_d.cfg = cfg_wdata[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;
    assign cfg = st_q.cfg;

    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> st_q.run);

    a_r2_entry_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> $past(pd_ok));

    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !cfg_we) |=> $stable(st_q.cfg));

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_in,
    output logic q
);

    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          q;
    } div_state_t;

    div_state_t dv_d, dv_q;
    logic       rise;

    assign rise = ref_in & ~dv_q.prev;

    always_comb begin
        dv_d      = dv_q;
        dv_d.prev = ref_in;
        if (clr) begin
            dv_d.cnt = '0;
            dv_d.q   = 1'b0;
        end else if (rise) begin
            if (dv_q.cnt == CW'(HALF - 1)) begin
                dv_d.cnt = '0;
                dv_d.q   = ~dv_q.q;
            end else begin
                dv_d.cnt = dv_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign q = dv_q.q;

    a_r6_toggle_on_ref_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dv_q.q) |-> $past(rise || clr));

endmodule

// File: rtl/out_gate.sv
module out_gate
    import clk_strap_gate_pkg::*;
#(
    parameter int         N      = 1,
    parameter gate_mode_e MODE   = GATE_LOW,
    parameter bit         RST_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src,
    input  logic [N-1:0] want,
    input  logic         pd_ok,
    output logic [N-1:0] dat,
    output logic [N-1:0] aux
);

    logic [N-1:0] en_d, en_q;

    // Enable follows its request only while the source waveform is low.
    always_comb begin
        en_d = en_q;
        if (!src) en_d = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= {N{RST_EN}};
        else        en_q <= en_d;
    end

    if (MODE == GATE_PAIR) begin : g_pair
        assign dat = {N{src & pd_ok}} & en_q;
        assign aux = {N{~src & pd_ok}} & en_q;
    end else if (MODE == GATE_HIZ) begin : g_hiz
        logic unused_pd;
        assign unused_pd = pd_ok;
        assign dat = {N{src}};
        assign aux = en_q;
    end else begin : g_low
        logic unused_pd;
        assign unused_pd = pd_ok;
        assign dat = {N{src}} & en_q;
        assign aux = {N{1'b1}};
    end

    a_r8_update_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> !$past(src));

endmodule

// File: rtl/clk_strap_gate.sv
module clk_strap_gate
    import clk_strap_gate_pkg::*;
#(
    parameter int N_CPU       = 7,
    parameter int N_PCIE      = 7,
    parameter int N_PCI       = 2,
    parameter int CPU_BYP_DIV = 4,
    parameter int SRC_BYP_DIV = 8,
    parameter int PCI_BYP_DIV = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pgood_pd_n,
    input  logic [2:0]          strap_fs,
    input  logic                strap_ss,
    input  logic                cfg_we,
    input  logic [CFG_BYTE-1:0] cfg_wdata,
    input  logic                ref_raw,
    input  logic                cpu_raw,
    input  logic                src_raw,
    input  logic                pci_raw,
    input  logic                c48_raw,
    input  logic                c25_raw,
    input  logic [2:0]          en_ref,
    input  logic [N_PCI-1:0]    en_pci,
    input  logic [1:0]          en_48,
    input  logic [1:0]          en_25,
    input  logic [N_CPU-1:0]    en_cpu,
    input  logic [N_PCIE-1:0]   en_pcie,
    output logic                pin_out_mode,
    output logic [CFG_BYTE-1:0] freq_cfg,
    output logic                ref0,
    output logic [1:0]          ref12,
    output logic [1:0]          ref12_oe,
    output logic [N_PCI-1:0]    pci_clk,
    output logic                pci_oe,
    output logic [1:0]          c48,
    output logic [1:0]          c25,
    output logic [1:0]          c25_oe,
    output logic [N_CPU-1:0]    cpu_t,
    output logic [N_CPU-1:0]    cpu_c,
    output logic                cpu_oe,
    output logic [N_PCIE-1:0]   pcie_t,
    output logic [N_PCIE-1:0]   pcie_c,
    output logic                pcie_oe
);

    localparam int N_DIV = 3;
    localparam int BYP_DIV [N_DIV] = '{CPU_BYP_DIV, SRC_BYP_DIV, PCI_BYP_DIV};

    logic             run, pd_ok, bypass, drive_on;
    logic [CFG_W-1:0] cfg;
    logic [N_DIV-1:0] byp_clk;
    logic             cpu_src, pcie_src, pci_src;
    logic             unused_ref0_aux;
    logic [N_PCI-1:0] unused_pci_aux;
    logic [1:0]       unused_c48_aux;
    logic             unused_c25_aux;

    strap_ctl u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgood_pd_n (pgood_pd_n),
        .strap_fs   (strap_fs),
        .strap_ss   (strap_ss),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .run        (run),
        .pd_ok      (pd_ok),
        .cfg        (cfg)
    );

    assign pin_out_mode = run;
    assign freq_cfg     = {{(CFG_BYTE-CFG_W){1'b0}}, cfg};
    assign bypass       = run & (cfg[FS_W-1:0] == FS_BYPASS);
    assign drive_on     = run & (cfg[FS_W-1:0] != FS_HIZ);
    assign cpu_oe       = drive_on;
    assign pcie_oe      = drive_on;
    assign pci_oe       = drive_on;

    for (genvar g = 0; g < N_DIV; g++) begin : g_byp
        ref_divider #(.DIV(BYP_DIV[g])) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (~bypass),
            .ref_in (ref_raw),
            .q      (byp_clk[g])
        );
    end

    assign cpu_src  = bypass ? byp_clk[0] : cpu_raw;
    assign pcie_src = bypass ? byp_clk[1] : src_raw;
    assign pci_src  = bypass ? byp_clk[2] : pci_raw;

    out_gate #(.N(1), .MODE(GATE_LOW), .RST_EN(1'b1)) u_ref0 (
        .clk(clk), .rst_n(rst_n), .src(ref_raw), .want(en_ref[0]),
        .pd_ok(1'b1), .dat(ref0), .aux(unused_ref0_aux)
    );

    out_gate #(.N(2), .MODE(GATE_HIZ)) u_ref12 (
        .clk(clk), .rst_n(rst_n), .src(ref_raw), .want({2{run}} & en_ref[2:1]),
        .pd_ok(1'b1), .dat(ref12), .aux(ref12_oe)
    );

    out_gate #(.N(N_PCI), .MODE(GATE_LOW)) u_pci (
        .clk(clk), .rst_n(rst_n), .src(pci_src), .want({N_PCI{run}} & en_pci),
        .pd_ok(1'b1), .dat(pci_clk), .aux(unused_pci_aux)
    );

    out_gate #(.N(2), .MODE(GATE_LOW)) u_c48 (
        .clk(clk), .rst_n(rst_n), .src(c48_raw), .want({2{run}} & en_48),
        .pd_ok(1'b1), .dat(c48), .aux(unused_c48_aux)
    );

    out_gate #(.N(1), .MODE(GATE_HIZ)) u_c25_hiz (
        .clk(clk), .rst_n(rst_n), .src(c25_raw), .want(run & en_25[0]),
        .pd_ok(1'b1), .dat(c25[0]), .aux(c25_oe[0])
    );

    out_gate #(.N(1), .MODE(GATE_LOW)) u_c25_low (
        .clk(clk), .rst_n(rst_n), .src(c25_raw), .want(run & en_25[1]),
        .pd_ok(1'b1), .dat(c25[1]), .aux(unused_c25_aux)
    );

    assign c25_oe[1] = 1'b1;

    out_gate #(.N(N_CPU), .MODE(GATE_PAIR)) u_cpu (
        .clk(clk), .rst_n(rst_n), .src(cpu_src),
        .want({N_CPU{run & pd_ok}} & en_cpu),
        .pd_ok(pd_ok), .dat(cpu_t), .aux(cpu_c)
    );

    out_gate #(.N(N_PCIE), .MODE(GATE_PAIR)) u_pcie (
        .clk(clk), .rst_n(rst_n), .src(pcie_src),
        .want({N_PCIE{run & pd_ok}} & en_pcie),
        .pd_ok(pd_ok), .dat(pcie_t), .aux(pcie_c)
    );

    a_r11_pd_pairs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_pd_n |-> (((cpu_t | cpu_c) == '0) && ((pcie_t | pcie_c) == '0)));

    a_r1_straps_are_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_out_mode |-> ((ref12_oe == 2'b00) && !c25_oe[0]));

endmodule

// File: tb/clk_strap_gate_bench.sv
module clk_strap_gate_bench;

    localparam int N_CPU  = 7;
    localparam int N_PCIE = 7;
    localparam int N_PCI  = 2;
    localparam int N_VEC  = 6;

    // {write data, expected freq_cfg, expected oe}
    localparam logic [16:0] VEC [N_VEC] = '{
        {8'h00, 8'h00, 1'b0},
        {8'hE3, 8'h03, 1'b1},
        {8'h10, 8'h10, 1'b0},
        {8'h08, 8'h08, 1'b1},
        {8'h1F, 8'h1F, 1'b1},
        {8'h04, 8'h04, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgood_pd_n = 1'b0;
    logic [2:0] strap_fs = 3'b101;
    logic strap_ss = 1'b1;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic ref_raw = 1'b0, cpu_raw = 1'b0, src_raw = 1'b0;
    logic pci_raw = 1'b0, c48_raw = 1'b0, c25_raw = 1'b0;
    logic [2:0] en_ref = 3'b111;
    logic [N_PCI-1:0] en_pci = '1;
    logic [1:0] en_48 = 2'b11;
    logic [1:0] en_25 = 2'b11;
    logic [N_CPU-1:0] en_cpu = '1;
    logic [N_PCIE-1:0] en_pcie = '1;

    logic pin_out_mode, ref0, pci_oe, cpu_oe, pcie_oe;
    logic [7:0] freq_cfg;
    logic [1:0] ref12, ref12_oe, c48, c25, c25_oe;
    logic [N_PCI-1:0] pci_clk;
    logic [N_CPU-1:0] cpu_t, cpu_c;
    logic [N_PCIE-1:0] pcie_t, pcie_c;

    int checks = 0;
    int fails = 0;
    bit cnt_on = 1'b0;
    int n_cpu = 0, n_pcie = 0, n_pci = 0;
    logic p_cpu = 1'b0, p_pcie = 1'b0, p_pci = 1'b0;

    always #4 clk = ~clk;

    clk_strap_gate u_clk_strap_gate (
        .clk(clk), .rst_n(rst_n), .pgood_pd_n(pgood_pd_n),
        .strap_fs(strap_fs), .strap_ss(strap_ss),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ref_raw(ref_raw), .cpu_raw(cpu_raw), .src_raw(src_raw),
        .pci_raw(pci_raw), .c48_raw(c48_raw), .c25_raw(c25_raw),
        .en_ref(en_ref), .en_pci(en_pci), .en_48(en_48), .en_25(en_25),
        .en_cpu(en_cpu), .en_pcie(en_pcie),
        .pin_out_mode(pin_out_mode), .freq_cfg(freq_cfg), .ref0(ref0),
        .ref12(ref12), .ref12_oe(ref12_oe), .pci_clk(pci_clk), .pci_oe(pci_oe),
        .c48(c48), .c25(c25), .c25_oe(c25_oe),
        .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe),
        .pcie_t(pcie_t), .pcie_c(pcie_c), .pcie_oe(pcie_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    always @(negedge clk) begin
        if (cnt_on) begin
            if (cpu_t[0] && !p_cpu)   n_cpu++;
            if (pcie_t[0] && !p_pcie) n_pcie++;
            if (pci_clk[0] && !p_pci) n_pci++;
        end
        p_cpu  = cpu_t[0];
        p_pcie = pcie_t[0];
        p_pci  = pci_clk[0];
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, pads are inputs
        chk("R1 out_mode", pin_out_mode, 0);
        chk("R1 ref12_oe", ref12_oe, 0);
        chk("R1 c25_oe0", c25_oe[0], 0);
        chk("R1 pairs", {cpu_t, cpu_c, pcie_t, pcie_c}, 0);

        // R12: ref0 runs before output mode
        ref_raw = 1'b1; #1;
        chk("R12 ref0 pre-run", ref0, 1);
        ref_raw = 1'b0;

        // R4: write before output mode is ignored, held across strap load
        cfg_we = 1'b1; cfg_wdata = 8'h1F;
        repeat (2) @(negedge clk);
        chk("R4 early write", freq_cfg, 8'h00);

        // R2: synchronized entry on third edge
        pgood_pd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet", pin_out_mode, 0);
        chk("R4 cfg before load", freq_cfg, 8'h00);
        @(negedge clk);
        chk("R2 entered", pin_out_mode, 1);
        chk("R3 strap image", freq_cfg, 8'h15);
        cfg_we = 1'b0;
        strap_fs = 3'b010; strap_ss = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 straps ignored", freq_cfg, 8'h15);
        chk("R1 pads now outputs", {ref12_oe, c25_oe}, 4'hF);

        // R4/R5: table of writes
        for (int i = 0; i < N_VEC; i++) begin
            wr(VEC[i][16:9]);
            chk("R4 cfg", freq_cfg, VEC[i][8:1]);
            chk("R5 cpu_oe", cpu_oe, VEC[i][0]);
            chk("R5 pcie_oe", pcie_oe, VEC[i][0]);
            chk("R5 pci_oe", pci_oe, VEC[i][0]);
        end

        // R7/R9: pass-through of pairs
        @(negedge clk);
        cpu_raw = 1'b1; src_raw = 1'b1; #1;
        chk("R7 cpu_t", cpu_t, 7'h7F);
        chk("R9 cpu_c", cpu_c, 0);
        chk("R7 pcie_t", pcie_t, 7'h7F);
        cpu_raw = 1'b0; src_raw = 1'b0; #1;
        chk("R9 cpu_c inv", cpu_c, 7'h7F);
        chk("R9 pcie_c inv", pcie_c, 7'h7F);

        // R8: disable deferred while source high
        @(negedge clk);
        cpu_raw = 1'b1; en_cpu[2] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 deferred", cpu_t[2], 1);
        cpu_raw = 1'b0;
        @(negedge clk);
        chk("R9 disabled c low", cpu_c[2], 0);
        chk("R9 others c", cpu_c[3], 1);
        cpu_raw = 1'b1;
        @(negedge clk);
        chk("R8 taken", cpu_t[2], 0);
        chk("R8 neighbour", cpu_t[3], 1);
        cpu_raw = 1'b0;
        en_cpu[2] = 1'b1;
        @(negedge clk);

        // R10: disabled states per class
        en_ref = 3'b000; en_pci = '0; en_48 = 2'b00; en_25 = 2'b00;
        @(negedge clk);
        ref_raw = 1'b1; pci_raw = 1'b1; c48_raw = 1'b1; c25_raw = 1'b1;
        @(negedge clk);
        chk("R10 ref0 low", ref0, 0);
        chk("R10 ref12 hiz", ref12_oe, 0);
        chk("R10 pci low", pci_clk, 0);
        chk("R10 c48 low", c48, 0);
        chk("R10 c25_1 low", {c25[1], c25_oe[1]}, 2'b01);
        chk("R10 c25_0 hiz", c25_oe[0], 0);
        ref_raw = 1'b0; pci_raw = 1'b0; c48_raw = 1'b0; c25_raw = 1'b0;
        en_ref = 3'b111; en_pci = '1; en_48 = 2'b11; en_25 = 2'b11;
        @(negedge clk);
        ref_raw = 1'b1; pci_raw = 1'b1; c48_raw = 1'b1; c25_raw = 1'b1;
        @(negedge clk);
        chk("R7 single-ended", {ref0, ref12, pci_clk, c48, c25}, 9'h1FF);
        chk("R7 oe", {ref12_oe, c25_oe}, 4'hF);
        ref_raw = 1'b0; pci_raw = 1'b0; c48_raw = 1'b0; c25_raw = 1'b0;
        @(negedge clk);

        // R11/R12: power-down
        chk("R11 before pd", cpu_c, 7'h7F);
        pgood_pd_n = 1'b0; #1;
        chk("R11 cpu immediate", cpu_c, 0);
        chk("R11 pcie immediate", pcie_c, 0);
        ref_raw = 1'b1; #1;
        chk("R12 ref0 in pd", ref0, 1);
        ref_raw = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 mode kept in pd", pin_out_mode, 1);
        pgood_pd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 still low", cpu_c, 0);
        @(negedge clk);
        chk("R11 resumed", cpu_c, 7'h7F);
        chk("R11 pcie resumed", pcie_c, 7'h7F);

        // R6: bypass dividers
        wr(8'h01);
        repeat (2) @(negedge clk);
        cnt_on = 1'b1;
        for (int k = 0; k < 48; k++) begin
            ref_raw = 1'b1;
            repeat (2) @(negedge clk);
            ref_raw = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        cnt_on = 1'b0;
        chk("R6 cpu /4", n_cpu, 12);
        chk("R6 pcie /8", n_pcie, 6);
        chk("R6 pci /24", n_pci, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule